// File: doc/BRIEF.md
# Multichannel IQ Parallel Output Framer

This block interleaves I/Q samples from up to sixteen downconverter channels onto one 16-bit I bus and one 16-bit Q bus. Each channel presents its words with a valid strobe; the framer keeps the most recent sample per channel and, once a master sync has started a frame, puts the channels out one after another, each for a programmable number of output-clock cycles. A frame strobe with programmable period, position and polarity marks the frame, and an output clock of selectable polarity goes with the data. A gain-monitor mode replaces the low byte of each bus with AGC gain and state.

The parallel path runs only while its enable bit is set. With the bit clear the framer sits idle, so another output path can own the pins. Four high-impedance bits turn off the output drivers in groups. Sequence settings are taken only when the sequence returns to channel 0, so a frame never mixes settings.

Top module: `iq_par_framer`

## Requirements
- R1: While reset is high or the enable bit is low, and after either until the next sync, both buses are 0 and the frame strobe sits at its inactive level.
- R2: If sync_in is high at rising edge n and the sync delay field is D, the channel 0 word is on the buses from rising edge n+D+2.
- R3: Channels come out in ascending order from 0 up to the channel count field N, then wrap to 0. N=0 gives one channel and N=15 gives sixteen.
- R4: Each channel word stays on the buses for V cycles, where V is the clock divide field. A value of 0 is treated as 1.
- R5: The first strobe after a sync comes S cycles after rising edge n+D+1, where S is the strobe delay field. S=0 puts it one cycle before the channel 0 word and S=1 aligns it with that word.
- R6: Strobes repeat every P+1 cycles, where P is the interval field value taken when the previous strobe was issued. P=0 gives a strobe on every cycle.
- R7: The frame strobe pin is active high when the sync polarity bit is 1 and active low when it is 0.
- R8: In gain-monitor mode I = {I[15:8], gain[13:6]} and Q = {Q[15:8], gain[5:0], agc_state[1:0]}. Otherwise I and Q pass through unchanged.
- R9: A channel's held sample changes only at an edge where its ch_valid bit is high. Changing a channel's inputs without its valid bit, or pulsing another channel's valid bit, leaves the output unchanged.
- R10: A change to the channel count, clock divide or gain-monitor bit made during a frame takes effect only when the sequence next returns to channel 0.
- R11: The output enables are active high and are the inverse of the high-impedance bits: bit 0 controls the I bus, bit 1 the Q bus, bit 2 the frame strobe and bit 3 the output clock.
- R12: The output clock equals clk when the clock polarity bit is 1 and the inverse of clk when it is 0. Data therefore launches on the output clock's rising edge in the first case and its falling edge in the second.
- R13: A sync that arrives while frames are running restarts the sequence at channel 0 and restarts the strobe schedule, using the same timing as R2 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_valid | input | NCH | Per-channel sample valid |
| ch_i | input | NCH*16 | Per-channel I words, channel c at [16c+15:16c] |
| ch_q | input | NCH*16 | Per-channel Q words |
| ch_gain | input | NCH*14 | Per-channel AGC gain |
| ch_agc | input | NCH*2 | Per-channel AGC state |
| sync_in | input | 1 | Master sync |
| cfg_ena | input | 1 | Parallel path enable |
| cfg_interval | input | 7 | Strobe interval minus one |
| cfg_div | input | 7 | Cycles per channel word |
| cfg_nch | input | 4 | Channel count minus one |
| cfg_sync_dly | input | 7 | Sync-to-frame delay |
| cfg_strobe_dly | input | 4 | Strobe position relative to channel 0 |
| cfg_clk_pol | input | 1 | Output clock polarity |
| cfg_sync_pol | input | 1 | Strobe polarity (1 = active high) |
| cfg_gain_mon | input | 1 | Gain-monitor packing |
| cfg_hiz | input | 4 | High-impedance bits {clk, strobe, Q, I} |
| rx_i | output | 16 | I output bus |
| rx_q | output | 16 | Q output bus |
| rx_sync | output | 1 | Frame strobe |
| rx_clk | output | 1 | Output clock |
| rx_i_oe | output | 1 | I bus driver enable |
| rx_q_oe | output | 1 | Q bus driver enable |
| rx_sync_oe | output | 1 | Strobe driver enable |
| rx_clk_oe | output | 1 | Clock driver enable |

## Verification
The assertions check on every cycle that the disabled path stays quiet with an inactive strobe, that a zero sync delay fires the frame start one cycle after sync, that the channel index never passes the channel count in force, that a restart returns the index to 0, and that a zero interval gives an unbroken run of strobes. How the sync delay, divide, channel count, strobe position and polarity combine over whole frames, the gain-monitor packing, capture on valid, the deferral of mid-frame changes and re-sync while running can only be shown by the bench's scenarios. The bench compares each output cycle against a frame model built from the field values.

// File: rtl/iqf_pkg.sv
`timescale 1ns/1ps
package iqf_pkg;

    localparam int IQ_W    = 16;
    localparam int GAIN_W  = 14;
    localparam int AGCST_W = 2;
    localparam int HALF_W  = IQ_W / 2;

    // one held sample of one channel
    typedef struct packed {
        logic [IQ_W-1:0]    i;
        logic [IQ_W-1:0]    q;
        logic [GAIN_W-1:0]  gain;
        logic [AGCST_W-1:0] agc;
    } chan_sample_t;

    // one word on the output buses
    typedef struct packed {
        logic [IQ_W-1:0] i;
        logic [IQ_W-1:0] q;
    } iq_word_t;

    // gain monitor: upper gain bits fill the low byte of I, the rest of the
    // gain and the AGC state fill the low byte of Q
    function automatic iq_word_t pack_out(chan_sample_t s, logic gain_mon);
        iq_word_t w;
        if (gain_mon) begin
            w.i = {s.i[IQ_W-1 -: HALF_W], s.gain[GAIN_W-1 -: HALF_W]};
            w.q = {s.q[IQ_W-1 -: HALF_W], s.gain[GAIN_W-HALF_W-1:0], s.agc};
        end else begin
            w.i = s.i;
            w.q = s.q;
        end
        return w;
    endfunction

endpackage

// File: rtl/iqf_sync_delay.sv
`timescale 1ns/1ps
module iqf_sync_delay #(
    parameter int DLY_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ena,
    input  logic             sync_in,
    input  logic [DLY_W-1:0] dly,
    output logic             fire
);
    logic [DLY_W-1:0] cnt;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst || !ena) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (sync_in) begin
            armed <= 1'b1;
            cnt   <= dly;
        end else if (armed) begin
            if (cnt == '0) armed <= 1'b0;
            else           cnt   <= cnt - 1'b1;
        end
    end

    // frame start lands on the edge that ends this cycle
    assign fire = armed && (cnt == '0);
endmodule

// File: rtl/iqf_slot_seq.sv
`timescale 1ns/1ps
module iqf_slot_seq #(
    parameter int CH_W  = 4,
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ena,
    input  logic             fire,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [CH_W-1:0]  cfg_nch,
    input  logic             cfg_gain_mon,
    output logic             running,
    output logic [CH_W-1:0]  ch_idx,
    output logic [CH_W-1:0]  act_nch,
    output logic             act_gm
);
    logic [DIV_W-1:0] act_div;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_last;

    assign div_last = (act_div == '0) ? '0 : act_div - 1'b1;

    always_ff @(posedge clk) begin
        if (rst || !ena) begin
            running <= 1'b0;
            ch_idx  <= '0;
            div_cnt <= '0;
            act_div <= '0;
            act_nch <= '0;
            act_gm  <= 1'b0;
        end else if (fire) begin
            running <= 1'b1;
            ch_idx  <= '0;
            div_cnt <= '0;
            act_div <= cfg_div;
            act_nch <= cfg_nch;
            act_gm  <= cfg_gain_mon;
        end else if (running) begin
            if (div_cnt == div_last) begin
                div_cnt <= '0;
                if (ch_idx == act_nch) begin
                    // frame boundary: new settings take hold here
                    ch_idx  <= '0;
                    act_div <= cfg_div;
                    act_nch <= cfg_nch;
                    act_gm  <= cfg_gain_mon;
                end else begin
                    ch_idx <= ch_idx + 1'b1;
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/iqf_strobe_gen.sv
`timescale 1ns/1ps
module iqf_strobe_gen #(
    parameter int INT_W = 7,
    parameter int SDLY_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ena,
    input  logic              fire,
    input  logic [INT_W-1:0]  cfg_interval,
    input  logic [SDLY_W-1:0] cfg_sdly,
    output logic              strobe_q,
    output logic [INT_W-1:0]  act_int
);
    logic              live;
    logic              waiting;
    logic [SDLY_W-1:0] wcnt;
    logic [INT_W-1:0]  per_cnt;

    always_ff @(posedge clk) begin
        if (rst || !ena) begin
            live     <= 1'b0;
            waiting  <= 1'b0;
            wcnt     <= '0;
            per_cnt  <= '0;
            act_int  <= '0;
            strobe_q <= 1'b0;
        end else if (fire) begin
            live     <= 1'b1;
            per_cnt  <= '0;
            act_int  <= cfg_interval;
            wcnt     <= cfg_sdly;
            waiting  <= (cfg_sdly != '0);
            strobe_q <= (cfg_sdly == '0);
        end else if (waiting) begin
            if (wcnt == SDLY_W'(1)) begin
                waiting  <= 1'b0;
                strobe_q <= 1'b1;
                per_cnt  <= '0;
                act_int  <= cfg_interval;
            end else begin
                wcnt     <= wcnt - 1'b1;
                strobe_q <= 1'b0;
            end
        end else if (live) begin
            if (per_cnt == act_int) begin
                per_cnt  <= '0;
                strobe_q <= 1'b1;
                act_int  <= cfg_interval;
            end else begin
                per_cnt  <= per_cnt + 1'b1;
                strobe_q <= 1'b0;
            end
        end else begin
            strobe_q <= 1'b0;
        end
    end
endmodule

// File: rtl/iq_par_framer.sv
`timescale 1ns/1ps
module iq_par_framer
    import iqf_pkg::*;
#(
    parameter int NCH        = 16,
    parameter int INT_W      = 7,
    parameter int DIV_W      = 7,
    parameter int SYNC_DLY_W = 7,
    parameter int STB_DLY_W  = 4,
    localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NCH-1:0]          ch_valid,
    input  logic [NCH*IQ_W-1:0]     ch_i,
    input  logic [NCH*IQ_W-1:0]     ch_q,
    input  logic [NCH*GAIN_W-1:0]   ch_gain,
    input  logic [NCH*AGCST_W-1:0]  ch_agc,
    input  logic                    sync_in,
    input  logic                    cfg_ena,
    input  logic [INT_W-1:0]        cfg_interval,
    input  logic [DIV_W-1:0]        cfg_div,
    input  logic [CH_W-1:0]         cfg_nch,
    input  logic [SYNC_DLY_W-1:0]   cfg_sync_dly,
    input  logic [STB_DLY_W-1:0]    cfg_strobe_dly,
    input  logic                    cfg_clk_pol,
    input  logic                    cfg_sync_pol,
    input  logic                    cfg_gain_mon,
    input  logic [3:0]              cfg_hiz,
    output logic [IQ_W-1:0]         rx_i,
    output logic [IQ_W-1:0]         rx_q,
    output logic                    rx_sync,
    output logic                    rx_clk,
    output logic                    rx_i_oe,
    output logic                    rx_q_oe,
    output logic                    rx_sync_oe,
    output logic                    rx_clk_oe
);
    logic             fire;
    logic             running;
    logic [CH_W-1:0]  ch_idx;
    logic [CH_W-1:0]  act_nch;
    logic             act_gm;
    logic             strobe_q;
    logic [INT_W-1:0] act_int;

    chan_sample_t hold_w [NCH];
    chan_sample_t cur;
    iq_word_t     out_q;

    // per-channel sample holding
    for (genvar c = 0; c < NCH; c++) begin : g_hold
        chan_sample_t r;
        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (ch_valid[c]) begin
                r.i    <= ch_i[c*IQ_W +: IQ_W];
                r.q    <= ch_q[c*IQ_W +: IQ_W];
                r.gain <= ch_gain[c*GAIN_W +: GAIN_W];
                r.agc  <= ch_agc[c*AGCST_W +: AGCST_W];
            end
        end
        assign hold_w[c] = r;
    end

    iqf_sync_delay #(.DLY_W(SYNC_DLY_W)) i_sync_delay (
        .clk     (clk),
        .rst     (rst),
        .ena     (cfg_ena),
        .sync_in (sync_in),
        .dly     (cfg_sync_dly),
        .fire    (fire)
    );

    iqf_slot_seq #(.CH_W(CH_W), .DIV_W(DIV_W)) i_slot_seq (
        .clk          (clk),
        .rst          (rst),
        .ena          (cfg_ena),
        .fire         (fire),
        .cfg_div      (cfg_div),
        .cfg_nch      (cfg_nch),
        .cfg_gain_mon (cfg_gain_mon),
        .running      (running),
        .ch_idx       (ch_idx),
        .act_nch      (act_nch),
        .act_gm       (act_gm)
    );

    iqf_strobe_gen #(.INT_W(INT_W), .SDLY_W(STB_DLY_W)) i_strobe_gen (
        .clk          (clk),
        .rst          (rst),
        .ena          (cfg_ena),
        .fire         (fire),
        .cfg_interval (cfg_interval),
        .cfg_sdly     (cfg_strobe_dly),
        .strobe_q     (strobe_q),
        .act_int      (act_int)
    );

    assign cur = hold_w[ch_idx];

    // output register: one stage after the slot sequencer
    always_ff @(posedge clk) begin
        if (rst || !cfg_ena || !running) out_q <= '0;
        else                              out_q <= pack_out(cur, act_gm);
    end

    assign rx_i       = out_q.i;
    assign rx_q       = out_q.q;
    assign rx_sync    = cfg_sync_pol ? strobe_q : ~strobe_q;
    assign rx_clk     = cfg_clk_pol ? clk : ~clk;
    assign rx_i_oe    = ~cfg_hiz[0];
    assign rx_q_oe    = ~cfg_hiz[1];
    assign rx_sync_oe = ~cfg_hiz[2];
    assign rx_clk_oe  = ~cfg_hiz[3];
endmodule

// File: rtl/iqf_checker.sv
`timescale 1ns/1ps
module iqf_checker #(
    parameter int CH_W  = 4,
    parameter int INT_W = 7,
    parameter int DLY_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_ena,
    input logic             sync_in,
    input logic [DLY_W-1:0] cfg_sync_dly,
    input logic             cfg_sync_pol,
    input logic [15:0]      rx_i,
    input logic [15:0]      rx_q,
    input logic             rx_sync,
    input logic             fire,
    input logic [CH_W-1:0]  ch_idx,
    input logic [CH_W-1:0]  act_nch,
    input logic             strobe_q,
    input logic [INT_W-1:0] act_int
);
    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg_ena |=> (rx_i == '0 && rx_q == '0 && rx_sync == !cfg_sync_pol));

    assert_zero_delay_start_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_ena && sync_in && cfg_sync_dly == '0) |=> fire);

    assert_index_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_ena |-> (ch_idx <= act_nch));

    assert_restart_at_zero_R13: assert property (@(posedge clk) disable iff (rst)
        (cfg_ena && fire) |=> (ch_idx == '0));

    assert_every_cycle_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        (cfg_ena && strobe_q && !fire && act_int == '0) |=> strobe_q);
endmodule

bind iq_par_framer iqf_checker #(
    .CH_W  (CH_W),
    .INT_W (INT_W),
    .DLY_W (SYNC_DLY_W)
) i_iqf_checker (
    .clk          (clk),
    .rst          (rst),
    .cfg_ena      (cfg_ena),
    .sync_in      (sync_in),
    .cfg_sync_dly (cfg_sync_dly),
    .cfg_sync_pol (cfg_sync_pol),
    .rx_i         (rx_i),
    .rx_q         (rx_q),
    .rx_sync      (rx_sync),
    .fire         (fire),
    .ch_idx       (ch_idx),
    .act_nch      (act_nch),
    .strobe_q     (strobe_q),
    .act_int      (act_int)
);

// File: tb/test_iq_par_framer.sv
`timescale 1ns/1ps
module test_iq_par_framer;
    localparam int NCH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0]    ch_valid = '0;
    logic [NCH*16-1:0] ch_i = '0;
    logic [NCH*16-1:0] ch_q = '0;
    logic [NCH*14-1:0] ch_gain = '0;
    logic [NCH*2-1:0]  ch_agc = '0;
    logic sync_in = 1'b0;
    logic cfg_ena = 1'b0;
    logic [6:0] cfg_interval = '0;
    logic [6:0] cfg_div = '0;
    logic [3:0] cfg_nch = '0;
    logic [6:0] cfg_sync_dly = '0;
    logic [3:0] cfg_strobe_dly = '0;
    logic cfg_clk_pol = 1'b0;
    logic cfg_sync_pol = 1'b0;
    logic cfg_gain_mon = 1'b0;
    logic [3:0] cfg_hiz = '0;
    logic [15:0] rx_i, rx_q;
    logic rx_sync, rx_clk, rx_i_oe, rx_q_oe, rx_sync_oe, rx_clk_oe;

    int n_tests = 0;
    int n_fail  = 0;

    logic [15:0] mi [NCH];
    logic [15:0] mq [NCH];
    logic [13:0] mg [NCH];
    logic [1:0]  ms [NCH];

    always #10 clk = ~clk;   // 50 MHz

    iq_par_framer i_iq_par_framer (
        .clk(clk), .rst(rst), .ch_valid(ch_valid), .ch_i(ch_i), .ch_q(ch_q),
        .ch_gain(ch_gain), .ch_agc(ch_agc), .sync_in(sync_in), .cfg_ena(cfg_ena),
        .cfg_interval(cfg_interval), .cfg_div(cfg_div), .cfg_nch(cfg_nch),
        .cfg_sync_dly(cfg_sync_dly), .cfg_strobe_dly(cfg_strobe_dly),
        .cfg_clk_pol(cfg_clk_pol), .cfg_sync_pol(cfg_sync_pol),
        .cfg_gain_mon(cfg_gain_mon), .cfg_hiz(cfg_hiz),
        .rx_i(rx_i), .rx_q(rx_q), .rx_sync(rx_sync), .rx_clk(rx_clk),
        .rx_i_oe(rx_i_oe), .rx_q_oe(rx_q_oe), .rx_sync_oe(rx_sync_oe), .rx_clk_oe(rx_clk_oe)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected bus word per R8
    function automatic logic [31:0] model_word(int ch, bit gm);
        logic [15:0] wi, wq;
        if (gm) begin
            wi = {mi[ch][15:8], mg[ch][13:6]};
            wq = {mq[ch][15:8], mg[ch][5:0], ms[ch]};
        end else begin
            wi = mi[ch];
            wq = mq[ch];
        end
        return {wi, wq};
    endfunction

    task automatic drive_bus();
        for (int c = 0; c < NCH; c++) begin
            ch_i[c*16 +: 16]   = mi[c];
            ch_q[c*16 +: 16]   = mq[c];
            ch_gain[c*14 +: 14] = mg[c];
            ch_agc[c*2 +: 2]   = ms[c];
        end
    endtask

    task automatic load_all();
        for (int c = 0; c < NCH; c++) begin
            mi[c] = 16'($urandom); mq[c] = 16'($urandom);
            mg[c] = 14'($urandom); ms[c] = 2'($urandom);
        end
        drive_bus();
        ch_valid = '1;
        @(negedge clk);
        ch_valid = '0;
    endtask

    // compare one output cycle, r = edges since frame-start edge
    task automatic expect_at(int r, int dv, int nc, int iv, int s, bit gm, bit pol, bit fresh);
        bit st;
        if (r >= 1)
            check("R2 R3 R4 R8 word", {rx_i, rx_q}, model_word(((r - 1) / dv) % (nc + 1), gm));
        else if (fresh)
            check("R1 R2 word before start", {rx_i, rx_q}, 32'h0);
        if (r >= 0 || fresh) begin
            st = (r >= s) && (((r - s) % (iv + 1)) == 0);
            check("R5 R6 R7 strobe", {31'h0, rx_sync}, {31'h0, pol ? st : !st});
        end
    endtask

    task automatic run_frames(int ncyc, bit fresh);
        int d, s, iv, dv, nc;
        bit gm, pol;
        d = cfg_sync_dly; s = cfg_strobe_dly; iv = cfg_interval;
        dv = (cfg_div == 0) ? 1 : cfg_div; nc = cfg_nch;
        gm = cfg_gain_mon; pol = cfg_sync_pol;
        if (fresh) begin
            cfg_ena = 1'b0;
            @(negedge clk);
            cfg_ena = 1'b1;
        end
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
        for (int k = 0; k < ncyc; k++) begin
            expect_at(k - d - 1, dv, nc, iv, s, gm, pol, fresh);
            @(negedge clk);
        end
    endtask

    task automatic set_cfg(int dv, int nc, int iv, int s, int d, bit gm, bit pol);
        cfg_div = 7'(dv); cfg_nch = 4'(nc); cfg_interval = 7'(iv);
        cfg_strobe_dly = 4'(s); cfg_sync_dly = 7'(d);
        cfg_gain_mon = gm; cfg_sync_pol = pol;
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] old_w;
        void'($urandom(32'h1A2B3C4D));
        for (int c = 0; c < NCH; c++) begin
            mi[c] = '0; mq[c] = '0; mg[c] = '0; ms[c] = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset word", {rx_i, rx_q}, 32'h0);
        check("R1 reset strobe inactive", {31'h0, rx_sync}, 32'h1);
        rst = 1'b0;
        cfg_ena = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 no sync no word", {rx_i, rx_q}, 32'h0);
        check("R1 no sync strobe", {31'h0, rx_sync}, 32'h1);

        // R11 output enables
        cfg_hiz = 4'b0101;
        #1;
        check("R11 enables", {28'h0, rx_clk_oe, rx_sync_oe, rx_q_oe, rx_i_oe}, 32'hA);
        cfg_hiz = 4'b1010;
        #1;
        check("R11 enables", {28'h0, rx_clk_oe, rx_sync_oe, rx_q_oe, rx_i_oe}, 32'h5);
        cfg_hiz = 4'b0000;

        // R12 clock polarity
        cfg_clk_pol = 1'b1;
        @(negedge clk); #1;
        check("R12 clock pol1 low phase", {31'h0, rx_clk}, 32'h0);
        @(posedge clk); #1;
        check("R12 clock pol1 high phase", {31'h0, rx_clk}, 32'h1);
        cfg_clk_pol = 1'b0;
        @(negedge clk); #1;
        check("R12 clock pol0 low phase", {31'h0, rx_clk}, 32'h1);
        @(negedge clk);

        // directed frames
        load_all();
        set_cfg(1, 3, 7, 1, 0, 0, 1);  run_frames(40, 1);
        set_cfg(3, 2, 5, 0, 5, 0, 0);  run_frames(50, 1);
        set_cfg(1, 15, 0, 2, 2, 1, 1); run_frames(40, 1);
        set_cfg(0, 0, 127, 15, 9, 1, 0); run_frames(60, 1);

        // constrained random configurations
        for (int t = 0; t < 24; t++) begin
            load_all();
            set_cfg($urandom % 5, $urandom % 16, $urandom % 40, $urandom % 16,
                    $urandom % 12, $urandom % 2, $urandom % 2);
            run_frames(90, 1);
        end

        // R10: mid-frame change waits for the return to channel 0
        load_all();
        set_cfg(2, 3, 100, 1, 0, 0, 1);
        cfg_ena = 1'b0; @(negedge clk); cfg_ena = 1'b1;
        sync_in = 1'b1; @(negedge clk); sync_in = 1'b0;
        for (int k = 0; k < 30; k++) begin
            int r;
            r = k - 1;
            if (r >= 1) begin
                if (r - 1 < 8)
                    check("R10 old frame kept", {rx_i, rx_q}, model_word(((r - 1) / 2) % 4, 0));
                else
                    check("R10 new settings", {rx_i, rx_q}, model_word((r - 9) % 2, 1));
            end
            if (r == 3) begin
                cfg_nch = 4'd1; cfg_div = 7'd1; cfg_gain_mon = 1'b1;
            end
            @(negedge clk);
        end

        // R13: re-sync while running
        load_all();
        set_cfg(2, 7, 9, 2, 3, 0, 1);
        run_frames(25, 1);
        set_cfg(1, 4, 6, 3, 2, 0, 1);
        run_frames(40, 0);

        // R9: capture only on own valid
        set_cfg(1, 0, 20, 1, 0, 0, 1);
        run_frames(6, 1);
        old_w = model_word(0, 0);
        mi[1] = ~mi[1]; mq[1] = ~mq[1];
        drive_bus(); ch_valid = 16'h0002;
        @(negedge clk); ch_valid = '0;
        @(negedge clk);
        check("R9 other valid ignored", {rx_i, rx_q}, old_w);
        mi[0] = ~mi[0]; mq[0] = ~mq[0];
        drive_bus();
        @(negedge clk); @(negedge clk);
        check("R9 no valid ignored", {rx_i, rx_q}, old_w);
        ch_valid = 16'h0001;
        @(negedge clk); ch_valid = '0;
        @(negedge clk);
        check("R9 own valid captured", {rx_i, rx_q}, model_word(0, 0));

        // R1: disabling while running
        cfg_ena = 1'b0;
        @(negedge clk);
        check("R1 disable word", {rx_i, rx_q}, 32'h0);
        check("R1 disable strobe", {31'h0, rx_sync}, 32'h0);
        cfg_ena = 1'b1;
        repeat (5) @(negedge clk);
        check("R1 re-enable waits for sync", {rx_i, rx_q}, 32'h0);
        check("R1 re-enable strobe", {31'h0, rx_sync}, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule